// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit virtual address into a physical address using a table of four segment descriptors kept in flip-flops. The two upper address bits choose a descriptor. The twelve lower bits are an offset within the segment. Each descriptor carries a physical base, a segment length and a 3-bit permission field. A request that passes every check returns base plus offset. A request that fails a check returns a fault flag and a cause code, and the physical address is forced to zero. Software loads the descriptors through a simple write port. Software also handles every fault, including copy-on-write, zero-fill and relocation.

Two descriptors may point at the same base with the same length but carry different permissions. This lets one physical region be shared writable through one segment number and read-only through another. Clearing the write bit of a descriptor makes any store through that segment trap, which is the hook copy-on-write needs.

Top module: `seg_xlate`

## Requirements
- R1: After reset all four descriptors are invalid, and rsp_valid, rsp_fault, rsp_cause and rsp_paddr are all zero.
- R2: The segment number is req_addr[13:12] and the offset is req_addr[11:0]. A request that does not fault returns rsp_paddr = base + offset, truncated to 16 bits.
- R3: rsp_valid is high exactly in the cycle after a cycle with req_valid high. When rsp_valid is low, rsp_fault, rsp_cause and rsp_paddr are zero.
- R4: An offset greater than or equal to the descriptor length gives a bounds fault, cause 2. A length of zero faults on every offset.
- R5: Permission bit 2 is valid, bit 1 is read-enable and bit 0 is write-enable. A read (req_write=0) with the read bit clear, or a write (req_write=1) with the write bit clear, gives a permission fault, cause 3.
- R6: A descriptor with the valid bit clear gives cause 1. Priority is invalid over bounds over permission.
- R7: rsp_fault is high exactly when rsp_cause is non-zero, and rsp_paddr is zero whenever rsp_fault is high.
- R8: A descriptor write applies to requests from the next cycle on. A request in the same cycle as a write to its own index is checked against the old descriptor.
- R9: Two descriptors with the same base and length but different permissions translate to the same physical address, and each faults according to its own permission field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 14 | Virtual address: segment[13:12], offset[11:0] |
| req_write | input | 1 | Access type: 1 = write, 0 = read |
| tbl_we | input | 1 | Descriptor write enable |
| tbl_idx | input | 2 | Descriptor index to write |
| tbl_base | input | 16 | Physical base to store |
| tbl_len | input | 13 | Segment length in bytes (0 to 4096) |
| tbl_perm | input | 3 | Permissions {valid, read, write} |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_paddr | output | 16 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 bounds, 3 permission |

## Verification
A descriptor write and a lookup of that same descriptor can land in the same cycle. The bench provokes this by driving tbl_we and req_valid on one clock edge, with the same segment number, while changing both the base and the permissions. The result must still reflect the old descriptor. A request issued on the very next cycle must then show the new base and the new fault behaviour. The bench also sets up accesses that break two or three rules at once, and judges that the reported cause follows the stated priority.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [SEG_BITS+OFF_BITS-1:0]  req_addr,
  input  logic                          req_write,
  input  logic                          tbl_we,
  input  logic [SEG_BITS-1:0]           tbl_idx,
  input  logic [PA_BITS-1:0]            tbl_base,
  input  logic [OFF_BITS:0]             tbl_len,
  input  logic [2:0]                    tbl_perm,
  output logic                          rsp_valid,
  output logic [PA_BITS-1:0]            rsp_paddr,
  output logic                          rsp_fault,
  output logic [1:0]                    rsp_cause
);
  localparam int NSEG   = 1 << SEG_BITS;
  localparam int VA_BITS = SEG_BITS + OFF_BITS;
  localparam int P_VAL  = 2;
  localparam int P_RD   = 1;
  localparam int P_WR   = 0;

  logic [PA_BITS-1:0]  base_q [NSEG];
  logic [OFF_BITS:0]   len_q  [NSEG];
  logic [2:0]          perm_q [NSEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (tbl_we) begin
      base_q[tbl_idx] <= tbl_base;
      len_q[tbl_idx]  <= tbl_len;
      perm_q[tbl_idx] <= tbl_perm;
    end
  end

  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic [2:0]          perm;
  logic                bad_val, bad_len, bad_acc;
  logic [1:0]          cause_d;
  logic [PA_BITS-1:0]  paddr_d;

  assign seg     = req_addr[VA_BITS-1:OFF_BITS];
  assign off     = req_addr[OFF_BITS-1:0];
  assign perm    = perm_q[seg];
  assign bad_val = !perm[P_VAL];
  assign bad_len = {1'b0, off} >= len_q[seg];
  assign bad_acc = req_write ? !perm[P_WR] : !perm[P_RD];
  assign cause_d = bad_val ? 2'd1 : bad_len ? 2'd2 : bad_acc ? 2'd3 : 2'd0;
  assign paddr_d = base_q[seg] + PA_BITS'(off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && (cause_d != 2'd0);
      rsp_cause <= req_valid ? cause_d : 2'd0;
      rsp_paddr <= (req_valid && cause_d == 2'd0) ? paddr_d : '0;
    end
  end
endmodule

module seg_xlate_chk #(
  parameter int PA_BITS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic [PA_BITS-1:0] rsp_paddr,
  input logic               rsp_fault,
  input logic [1:0]         rsp_cause
);
  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R3
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_fault && rsp_cause == 2'd0 && rsp_paddr == '0));
  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault == (rsp_cause != 2'd0));
  // R7
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_BITS(PA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic [15:0] tbl_base = '0;
  logic [12:0] tbl_len = '0;
  logic [2:0]  tbl_perm = '0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_base [4];
  logic [12:0] m_len  [4];
  logic [2:0]  m_perm [4];

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .tbl_perm(tbl_perm),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [13:0] va, input logic wr,
                                output logic [15:0] pa, output logic [1:0] cause);
    logic [1:0]  s;
    logic [11:0] o;
    s = va[13:12];
    o = va[11:0];
    if (!m_perm[s][2])                      cause = 2'd1;
    else if ({1'b0, o} >= m_len[s])         cause = 2'd2;
    else if (wr ? !m_perm[s][0] : !m_perm[s][1]) cause = 2'd3;
    else                                    cause = 2'd0;
    pa = (cause == 2'd0) ? m_base[s] + {4'h0, o} : 16'h0;
  endfunction

  task automatic load(input logic [1:0] idx, input logic [15:0] b,
                      input logic [12:0] l, input logic [2:0] p);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_base = b; tbl_len = l; tbl_perm = p;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[idx] = b; m_len[idx] = l; m_perm[idx] = p;
  endtask

  task automatic access(input string tag, input logic [13:0] va, input logic wr);
    logic [15:0] pa;
    logic [1:0]  cause;
    model(va, wr, pa, cause);
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " cause"}, rsp_cause, cause);
    chk({tag, " fault"}, rsp_fault, cause != 2'd0);
    chk({tag, " paddr"}, rsp_paddr, pa);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset valid", rsp_valid, 0);
    chk("R1 reset fault", rsp_fault, 0);
    chk("R1 reset cause", rsp_cause, 0);
    chk("R1 reset paddr", rsp_paddr, 0);
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_len[i] = '0; m_perm[i] = '0;
    end
    access("R1 empty table invalid", 14'h2010, 1'b0);
    chk("R1 cause is invalid", rsp_cause, 1);
  endtask

  task automatic t_translate;
    load(2'd0, 16'h1000, 13'h100, 3'b110);
    load(2'd1, 16'hF800, 13'h1000, 3'b111);
    access("R2 seg0 read", 14'h0042, 1'b0);
    chk("R2 seg0 addr", rsp_paddr, 16'h1042);
    access("R2 seg1 write", 14'h1123, 1'b1);
    chk("R2 seg1 addr", rsp_paddr, 16'hF923);
    access("R2 seg1 wrap", 14'h1FFF, 1'b0);
    chk("R2 wrap addr", rsp_paddr, 16'h07FF);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R3 idle valid", rsp_valid, 0);
    chk("R3 idle fault", rsp_fault, 0);
    chk("R3 idle paddr", rsp_paddr, 0);
  endtask

  task automatic t_bounds;
    access("R4 last byte", 14'h00FF, 1'b0);
    chk("R4 last byte ok", rsp_cause, 0);
    access("R4 at length", 14'h0100, 1'b0);
    chk("R4 at length cause", rsp_cause, 2);
    load(2'd2, 16'h3000, 13'h0, 3'b111);
    access("R4 zero length", 14'h2000, 1'b0);
    chk("R4 zero length cause", rsp_cause, 2);
  endtask

  task automatic t_perm;
    access("R5 write read-only", 14'h0010, 1'b1);
    chk("R5 ro write cause", rsp_cause, 3);
    chk("R7 ro write paddr", rsp_paddr, 0);
    load(2'd2, 16'h3000, 13'h200, 3'b101);
    access("R5 read write-only", 14'h2004, 1'b0);
    chk("R5 wo read cause", rsp_cause, 3);
    access("R5 write write-only", 14'h2004, 1'b1);
    chk("R5 wo write ok", rsp_paddr, 16'h3004);
  endtask

  task automatic t_priority;
    access("R6 bounds over perm", 14'h0300, 1'b1);
    chk("R6 bounds wins", rsp_cause, 2);
    load(2'd3, 16'h5000, 13'h0, 3'b000);
    access("R6 invalid over all", 14'h3400, 1'b1);
    chk("R6 invalid wins", rsp_cause, 1);
  endtask

  task automatic t_shared;
    load(2'd2, 16'h4000, 13'h800, 3'b111);
    load(2'd3, 16'h4000, 13'h800, 3'b110);
    access("R9 shared rw read", 14'h2123, 1'b0);
    chk("R9 rw addr", rsp_paddr, 16'h4123);
    access("R9 shared ro read", 14'h3123, 1'b0);
    chk("R9 ro addr", rsp_paddr, 16'h4123);
    access("R9 shared rw write", 14'h2123, 1'b1);
    chk("R9 rw write ok", rsp_cause, 0);
    access("R9 shared ro write", 14'h3123, 1'b1);
    chk("R9 ro write faults", rsp_cause, 3);
  endtask

  task automatic t_same_cycle;
    logic [15:0] pa;
    logic [1:0]  cause;
    model(14'h3010, 1'b1, pa, cause);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'd3; tbl_base = 16'h9000; tbl_len = 13'h40; tbl_perm = 3'b111;
    req_valid = 1'b1; req_addr = 14'h3010; req_write = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R8 same cycle old cause", rsp_cause, cause);
    chk("R8 same cycle old paddr", rsp_paddr, pa);
    m_base[3] = 16'h9000; m_len[3] = 13'h40; m_perm[3] = 3'b111;
    access("R8 next cycle new", 14'h3010, 1'b1);
    chk("R8 new entry addr", rsp_paddr, 16'h9010);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_translate();
    t_idle();
    t_bounds();
    t_perm();
    t_priority();
    t_shared();
    t_same_cycle();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule